// File: doc/BRIEF.md
# Colour LCD Controller Register Bank

This block is the software-visible register bank of a simple colour LCD controller. It sits behind a 32-bit slave port. The port addresses words through a 12-bit byte offset. The bank holds four timing words, the frame base addresses of the upper and lower panels, a control word and the interrupt mask, raw status and masked status. It also has a clear register where a written 1 clears a status bit, eight identification bytes that can only be read, and a window that forwards accesses to an external palette memory.

From the stored words the bank decodes values that the rest of the controller uses:
- the panel width in pixels and the panel height in lines;
- the pixel depth code and the colour and byte-order selects;
- a display-enable flag.

It also drives a level interrupt and pulses an invalidate strobe after every accepted write. A two-bit variant strap picks the identification byte set. It also selects whether the mask and control registers sit at their base offsets or at exchanged offsets. Read data is registered and appears one cycle after the read request.

Top module: `lcdc_regbank`

## Requirements
- R1: After a synchronous reset every stored word is zero. `irq`, `disp_en` and `bus_rdata` are then 0, and the decoded width is 16 and the height is 1.
- R2: Word offsets 0 to 3 (byte 0x00 to 0x0C) hold timing words 0 to 3. Offset 4 (0x10) holds the upper base and offset 5 (0x14) the lower base. Offsets 11 (0x2C) and 12 (0x30) read back the upper and lower base. A read returns its data on `bus_rdata` in the cycle after the request.
- R3: With `variant` = 0, word 6 (0x18) is the interrupt mask and word 7 (0x1C) is the control word. With any other `variant` the two are exchanged, for both reads and writes.
- R4: `disp_cols` = ((timing0 AND 0xFC) + 4) * 4. `disp_rows` = timing1[9:0] + 1. Each changes only after a write to its timing word.
- R5: `depth` = control[3:1], `bgr_order` = control[8], `be_bytes` = control[9] and `be_pixels` = control[10].
- R6: `disp_en` is 1 only when control bit 0 and control bit 11 are both 1. It can rise only in the cycle after a control write.
- R7: A 1 on `irq_set[i]` sets raw status bit i at the next edge. Word 8 (0x20) reads raw status. Word 9 (0x24) reads raw AND mask. `irq` is the OR of the masked bits.
- R8: Writing word 10 (0x28) clears each raw bit written as 1, except where `irq_set` sets the same bit in that cycle, in which case the set wins. Word 10 reads as zero, and raw bits never fall without such a write.
- R9: Byte offsets 0xFE0 to 0xFFC return one identification byte per word, at index (offset-0xFE0)>>2. `variant` 2 or 3 returns 11 11 24 00 0D F0 05 B1 in index order. `variant` 0 or 1 returns 10 11 04 00 0D F0 05 B1.
- R10: Byte offsets 0x200 to 0x3FF assert `pal_sel`, with `pal_idx` = (offset-0x200)>>2, and forward `pal_wr` and `pal_wdata`. A read there returns the `pal_rdata` value present in the request cycle.
- R11: Undefined offsets (for example word 13, 0x34) read as zero. A write there changes no register and raises no invalidate.
- R12: `invalidate` is high for exactly the one cycle that follows each write to a timing, base, mask, control or clear register or to the palette window. It is low otherwise.
- R13: `bus_rdata` is zero in every cycle that does not follow a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| variant | input | 2 | 0 base, 1 base ID with exchanged offsets, 2/3 extended |
| bus_sel | input | 1 | Access request |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after request |
| irq_set | input | 4 | Status set pulses |
| pal_sel | output | 1 | Palette window access |
| pal_wr | output | 1 | Palette write |
| pal_idx | output | 7 | Palette word index |
| pal_wdata | output | 32 | Palette write data |
| pal_rdata | input | 32 | Palette read data |
| disp_cols | output | 11 | Panel width in pixels |
| disp_rows | output | 11 | Panel height in lines |
| depth | output | 3 | Pixel depth code |
| bgr_order | output | 1 | Blue-first colour order |
| be_bytes | output | 1 | Big-endian byte order |
| be_pixels | output | 1 | Big-endian pixel order |
| disp_en | output | 1 | Display enabled |
| irq | output | 1 | Interrupt |
| invalidate | output | 1 | One-cycle strobe after a write |

## Verification
Read data is due one cycle after the request edge, so the bench's driver pushes each expected word into a queue. A monitor compares it at the falling edge that follows the capturing edge. The stored state and its decoded outputs are due at the edge that takes the write, and `invalidate` is high during the cycle after that edge. The bench therefore samples decoded fields, the strobe and `irq` at the falling edge just after the write or status-set cycle. The palette forwarding outputs are combinational and are sampled in the middle of the request cycle.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;

    parameter int ADDR_W  = 12;
    parameter int DATA_W  = 32;
    parameter int IRQ_W   = 4;
    parameter int PAL_W   = 7;
    parameter int GEOM_W  = 11;
    parameter int N_TIME  = 4;

    localparam logic [1:0] VAR_BASE  = 2'd0;

    typedef enum logic [3:0] {
        SL_NONE,
        SL_TIME,
        SL_UPB,
        SL_LPB,
        SL_MASK,
        SL_CTRL,
        SL_RAW,
        SL_MSKD,
        SL_CLR,
        SL_UPCUR,
        SL_LPCUR,
        SL_ID,
        SL_PAL
    } slot_e;

    typedef struct packed {
        slot_e             slot;
        logic [1:0]        tsel;
        logic [PAL_W-1:0]  pal_idx;
        logic [2:0]        id_idx;
    } dec_t;

    typedef struct packed {
        logic [2:0] depth;
        logic       bgr;
        logic       be_bytes;
        logic       be_pixels;
        logic       enable;
    } ctrl_view_t;

    function automatic logic [7:0] id_byte(input logic ext, input logic [2:0] idx);
        logic [7:0] b;
        case (idx)
            3'd0: b = ext ? 8'h11 : 8'h10;
            3'd1: b = 8'h11;
            3'd2: b = ext ? 8'h24 : 8'h04;
            3'd3: b = 8'h00;
            3'd4: b = 8'h0D;
            3'd5: b = 8'hF0;
            3'd6: b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

    function automatic ctrl_view_t ctrl_fields(input logic [DATA_W-1:0] c);
        ctrl_view_t v;
        v.depth     = c[3:1];
        v.bgr       = c[8];
        v.be_bytes  = c[9];
        v.be_pixels = c[10];
        v.enable    = c[0] & c[11];
        return v;
    endfunction

endpackage

// File: rtl/lcdc_decode.sv
module lcdc_decode
    import lcdc_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        variant,
    output dec_t              dec
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic              swap;

    assign word = addr[ADDR_W-1:2];
    assign swap = (variant != VAR_BASE);

    always_comb begin
        dec         = '0;
        dec.slot    = SL_NONE;
        if (addr[11:9] == 3'b001) begin
            dec.slot    = SL_PAL;
            dec.pal_idx = addr[PAL_W+1:2];
        end else if (addr[11:5] == 7'h7F) begin
            dec.slot   = SL_ID;
            dec.id_idx = addr[4:2];
        end else begin
            case (word)
                WORD_W'(0), WORD_W'(1), WORD_W'(2), WORD_W'(3): begin
                    dec.slot = SL_TIME;
                    dec.tsel = word[1:0];
                end
                WORD_W'(4):  dec.slot = SL_UPB;
                WORD_W'(5):  dec.slot = SL_LPB;
                WORD_W'(6):  dec.slot = swap ? SL_CTRL : SL_MASK;
                WORD_W'(7):  dec.slot = swap ? SL_MASK : SL_CTRL;
                WORD_W'(8):  dec.slot = SL_RAW;
                WORD_W'(9):  dec.slot = SL_MSKD;
                WORD_W'(10): dec.slot = SL_CLR;
                WORD_W'(11): dec.slot = SL_UPCUR;
                WORD_W'(12): dec.slot = SL_LPCUR;
                default:     dec.slot = SL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/lcdc_irq_unit.sv
module lcdc_irq_unit
    import lcdc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             mask_we,
    input  logic             clr_we,
    input  logic [IRQ_W-1:0] wdata,
    input  logic [IRQ_W-1:0] set_in,
    output logic [IRQ_W-1:0] raw,
    output logic [IRQ_W-1:0] mask,
    output logic [IRQ_W-1:0] masked,
    output logic             irq
);
    logic [IRQ_W-1:0] clr_bits;

    assign clr_bits = clr_we ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw  <= '0;
            mask <= '0;
        end else begin
            raw <= (raw & ~clr_bits) | set_in;
            if (mask_we) begin
                mask <= wdata;
            end
        end
    end

    assign masked = raw & mask;
    assign irq    = |masked;

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
        clr_we |=> ((raw & $past(wdata & ~set_in)) == '0)); // R8

    AST_RAW_STICKY: assert property (@(posedge clk) disable iff (rst)
        !clr_we |=> ((~raw & $past(raw)) == '0)); // R8
endmodule

// File: rtl/lcdc_regbank.sv
module lcdc_regbank
    import lcdc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          variant,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [IRQ_W-1:0]    irq_set,
    output logic                pal_sel,
    output logic                pal_wr,
    output logic [PAL_W-1:0]    pal_idx,
    output logic [DATA_W-1:0]   pal_wdata,
    input  logic [DATA_W-1:0]   pal_rdata,
    output logic [GEOM_W-1:0]   disp_cols,
    output logic [GEOM_W-1:0]   disp_rows,
    output logic [2:0]          depth,
    output logic                bgr_order,
    output logic                be_bytes,
    output logic                be_pixels,
    output logic                disp_en,
    output logic                irq,
    output logic                invalidate
);
    dec_t               dec;
    logic               wr_req;
    logic               rd_req;
    logic               wr_valid;
    logic [DATA_W-1:0]  timing [N_TIME];
    logic [DATA_W-1:0]  up_base;
    logic [DATA_W-1:0]  lo_base;
    logic [DATA_W-1:0]  ctrl;
    logic [IRQ_W-1:0]   raw_st;
    logic [IRQ_W-1:0]   mask_st;
    logic [IRQ_W-1:0]   mskd_st;
    logic [DATA_W-1:0]  rd_mux;
    ctrl_view_t         cv;

    lcdc_decode u_dec (
        .addr    (bus_addr),
        .variant (variant),
        .dec     (dec)
    );

    assign wr_req = bus_sel & bus_wr;
    assign rd_req = bus_sel & ~bus_wr;

    genvar gi;
    generate
        for (gi = 0; gi < N_TIME; gi++) begin : g_time
            always_ff @(posedge clk) begin
                if (rst) begin
                    timing[gi] <= '0;
                end else if (wr_req && dec.slot == SL_TIME && dec.tsel == 2'(gi)) begin
                    timing[gi] <= bus_wdata;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            up_base <= '0;
            lo_base <= '0;
            ctrl    <= '0;
        end else if (wr_req) begin
            if (dec.slot == SL_UPB)  up_base <= bus_wdata;
            if (dec.slot == SL_LPB)  lo_base <= bus_wdata;
            if (dec.slot == SL_CTRL) ctrl    <= bus_wdata;
        end
    end

    lcdc_irq_unit u_irq (
        .clk     (clk),
        .rst     (rst),
        .mask_we (wr_req && dec.slot == SL_MASK),
        .clr_we  (wr_req && dec.slot == SL_CLR),
        .wdata   (bus_wdata[IRQ_W-1:0]),
        .set_in  (irq_set),
        .raw     (raw_st),
        .mask    (mask_st),
        .masked  (mskd_st),
        .irq     (irq)
    );

    // geometry: width from packed field in timing0, height from timing1
    assign disp_cols = {GEOM_W'({1'b0, timing[0][7:2]}) + GEOM_W'(1)} << 4;
    assign disp_rows = GEOM_W'(timing[1][9:0]) + GEOM_W'(1);

    assign cv        = ctrl_fields(ctrl);
    assign depth     = cv.depth;
    assign bgr_order = cv.bgr;
    assign be_bytes  = cv.be_bytes;
    assign be_pixels = cv.be_pixels;
    assign disp_en   = cv.enable;

    assign pal_sel   = bus_sel && dec.slot == SL_PAL;
    assign pal_wr    = pal_sel && bus_wr;
    assign pal_idx   = dec.pal_idx;
    assign pal_wdata = bus_wdata;

    always_comb begin
        case (dec.slot)
            SL_TIME:           rd_mux = timing[dec.tsel];
            SL_UPB, SL_UPCUR:  rd_mux = up_base;
            SL_LPB, SL_LPCUR:  rd_mux = lo_base;
            SL_CTRL:           rd_mux = ctrl;
            SL_MASK:           rd_mux = DATA_W'(mask_st);
            SL_RAW:            rd_mux = DATA_W'(raw_st);
            SL_MSKD:           rd_mux = DATA_W'(mskd_st);
            SL_ID:             rd_mux = DATA_W'(id_byte(variant[1], dec.id_idx));
            SL_PAL:            rd_mux = pal_rdata;
            default:           rd_mux = '0;
        endcase
    end

    always_comb begin
        case (dec.slot)
            SL_TIME, SL_UPB, SL_LPB, SL_MASK,
            SL_CTRL, SL_CLR, SL_PAL: wr_valid = wr_req;
            default:                 wr_valid = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata  <= '0;
            invalidate <= 1'b0;
        end else begin
            bus_rdata  <= rd_req ? rd_mux : '0;
            invalidate <= wr_valid;
        end
    end

    AST_INVAL_AFTER_WR: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> invalidate); // R12

    AST_INVAL_ONLY_WR: assert property (@(posedge clk) disable iff (rst)
        !wr_valid |=> !invalidate); // R12

    AST_EN_BY_CTRL: assert property (@(posedge clk) disable iff (rst)
        $rose(disp_en) |-> $past(wr_req && dec.slot == SL_CTRL)); // R6

    AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> (bus_rdata == '0)); // R13

    AST_ROWS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(wr_req && dec.slot == SL_TIME && dec.tsel == 2'd1) |=> $stable(disp_rows)); // R4
endmodule

// File: tb/lcdc_regbank_tb.sv
module lcdc_regbank_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  variant = 2'd0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq_set = '0;
    logic        pal_sel, pal_wr;
    logic [6:0]  pal_idx;
    logic [31:0] pal_wdata, pal_rdata;
    logic [10:0] disp_cols, disp_rows;
    logic [2:0]  depth;
    logic        bgr_order, be_bytes, be_pixels, disp_en, irq, invalidate;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        due = 1'b0;

    always #10 clk = ~clk;

    assign pal_rdata = {16'hC0DE, 9'd0, pal_idx};

    lcdc_regbank u_dut (
        .clk(clk), .rst(rst), .variant(variant),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_set(irq_set),
        .pal_sel(pal_sel), .pal_wr(pal_wr), .pal_idx(pal_idx),
        .pal_wdata(pal_wdata), .pal_rdata(pal_rdata),
        .disp_cols(disp_cols), .disp_rows(disp_rows), .depth(depth),
        .bgr_order(bgr_order), .be_bytes(be_bytes), .be_pixels(be_pixels),
        .disp_en(disp_en), .irq(irq), .invalidate(invalidate)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    // driver: one write cycle, returns at the falling edge after the write edge
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    // driver: one read cycle, expected word goes to the scoreboard
    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_sel = 0;
    endtask

    // monitor
    always @(posedge clk) due <= bus_sel && !bus_wr;
    always @(negedge clk) begin
        if (due && exp_q.size() > 0) begin
            check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
    end

    localparam logic [7:0] ID_BASE [8] = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    localparam logic [7:0] ID_EXT  [8] = '{8'h11, 8'h11, 8'h24, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 disp_en", {31'd0, disp_en}, 32'd0);
        check("R1 rdata", bus_rdata, 32'd0);
        check("R1 cols", {21'd0, disp_cols}, 32'd16);
        check("R1 rows", {21'd0, disp_rows}, 32'd1);
        rd(12'h000, 32'd0, "R1 timing0");
        rd(12'h01C, 32'd0, "R1 ctrl");

        // R2 storage and current-address aliases
        wr(12'h008, 32'hDEAD_0002);
        wr(12'h00C, 32'h1234_5678);
        wr(12'h010, 32'h8000_1000);
        wr(12'h014, 32'h8004_0000);
        rd(12'h008, 32'hDEAD_0002, "R2 timing2");
        rd(12'h00C, 32'h1234_5678, "R2 timing3");
        rd(12'h010, 32'h8000_1000, "R2 upbase");
        rd(12'h014, 32'h8004_0000, "R2 lpbase");
        rd(12'h02C, 32'h8000_1000, "R2 upcur");
        rd(12'h030, 32'h8004_0000, "R2 lpcur");

        // R4 geometry and R12 strobe
        wr(12'h000, 32'hFFFF_FF13);
        check("R12 inval after write", {31'd0, invalidate}, 32'd1);
        check("R4 cols 0x13", {21'd0, disp_cols}, 32'd80);
        @(negedge clk);
        check("R12 inval one cycle", {31'd0, invalidate}, 32'd0);
        wr(12'h000, 32'h0000_00FC);
        check("R4 cols max", {21'd0, disp_cols}, 32'd1024);
        wr(12'h004, 32'hFFFF_F9DF);
        check("R4 rows 480", {21'd0, disp_rows}, 32'd480);
        wr(12'h004, 32'h0000_03FF);
        check("R4 rows max", {21'd0, disp_rows}, 32'd1024);

        // R5/R6 control decode, variant 0 control at 0x1C
        wr(12'h01C, 32'h0000_0F0B);
        check("R5 depth", {29'd0, depth}, 32'd5);
        check("R5 order bits", {29'd0, bgr_order, be_bytes, be_pixels}, 32'd7);
        check("R6 enable both", {31'd0, disp_en}, 32'd1);
        wr(12'h01C, 32'h0000_000B);
        check("R6 no power", {31'd0, disp_en}, 32'd0);
        wr(12'h01C, 32'h0000_0800);
        check("R6 no enable bit", {31'd0, disp_en}, 32'd0);
        check("R5 order cleared", {29'd0, bgr_order, be_bytes, be_pixels}, 32'd0);

        // R7 status / mask, R3 mask at 0x18 in variant 0
        @(negedge clk); irq_set = 4'b0101;
        @(negedge clk); irq_set = 4'b0000;
        check("R7 irq masked off", {31'd0, irq}, 32'd0);
        rd(12'h020, 32'h5, "R7 raw");
        rd(12'h024, 32'h0, "R7 masked none");
        wr(12'h018, 32'h0000_0004);
        check("R7 irq on", {31'd0, irq}, 32'd1);
        rd(12'h024, 32'h4, "R7 masked");
        rd(12'h018, 32'h4, "R3 mask at 6 base");
        rd(12'h01C, 32'h800, "R3 ctrl at 7 base");

        // R8 clear
        wr(12'h028, 32'h0000_0004);
        check("R8 irq cleared", {31'd0, irq}, 32'd0);
        rd(12'h020, 32'h1, "R8 raw after clear");
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = 12'h028; bus_wdata = 32'h1; irq_set = 4'b0001;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; irq_set = 4'b0000;
        rd(12'h020, 32'h1, "R8 set wins");
        rd(12'h028, 32'h0, "R8 clr reads zero");

        // R3 swapped variant
        variant = 2'd1;
        rd(12'h018, 32'h800, "R3 ctrl at 6 swapped");
        rd(12'h01C, 32'h4, "R3 mask at 7 swapped");
        wr(12'h018, 32'h0000_0801);
        check("R3 ctrl write at 6", {31'd0, disp_en}, 32'd1);
        wr(12'h01C, 32'h0000_0001);
        rd(12'h024, 32'h1, "R3 mask write at 7");

        // R9 ID bytes
        for (int k = 0; k < 8; k++) rd(12'hFE0 + 12'(k*4), {24'd0, ID_BASE[k]}, "R9 base id");
        variant = 2'd2;
        for (int k = 0; k < 8; k++) rd(12'hFE0 + 12'(k*4), {24'd0, ID_EXT[k]}, "R9 ext id");

        // R10 palette window
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = 12'h3FC; bus_wdata = 32'hABCD_0123;
        #5;
        check("R10 pal_sel", {31'd0, pal_sel}, 32'd1);
        check("R10 pal_wr", {31'd0, pal_wr}, 32'd1);
        check("R10 pal_idx", {25'd0, pal_idx}, 32'd127);
        check("R10 pal_wdata", pal_wdata, 32'hABCD_0123);
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
        check("R12 inval palette", {31'd0, invalidate}, 32'd1);
        rd(12'h204, {16'hC0DE, 16'd1}, "R10 pal read");
        @(negedge clk);
        bus_addr = 12'h1FC; #5;
        check("R10 no sel outside", {31'd0, pal_sel}, 32'd0);

        // R11 undefined offsets
        wr(12'h034, 32'hFFFF_FFFF);
        check("R11 no inval", {31'd0, invalidate}, 32'd0);
        rd(12'h034, 32'h0, "R11 read zero");
        rd(12'h000, 32'h0000_00FC, "R11 timing0 unchanged");
        wr(12'h020, 32'hFFFF_FFFF);
        check("R11 ro no inval", {31'd0, invalidate}, 32'd0);

        // R13 idle read data
        @(negedge clk);
        check("R13 idle rdata", bus_rdata, 32'd0);

        repeat (3) @(negedge clk);
        summary();
    end
endmodule